// File: doc/BRIEF.md
# Sequential Booth Shift-Add Multiplier

This block multiplies two N-bit operands over several clock cycles and returns a 2N-bit product, split into a high word and a low word. One mode input chooses how the operands are read. In signed mode they are two's complement values, and each step is picked by radix-2 Booth recoding. In unsigned mode they are plain binary values, and the block uses a conditional add followed by a shift. N defaults to 32.

A single start pulse, given while the block is idle, captures both operands and the mode. The block then raises busy for N cycles. It has one product register, with the multiplier held in the lower half. An N-bit adder/subtractor works on the upper half, plus one guard bit. On every busy cycle the register shifts right by one place. When the last step is written, done pulses for one cycle and the high and low result words update. Those words then hold until the next multiply finishes.

Top module: `booth_seq_mul`

## Requirements
- R1: Synchronous reset leaves busy_o and done_o low and hi_o and lo_o at zero.
- R2: start_i sampled high while idle captures the operands and the mode. busy_o is high from the next cycle. done_o rises exactly N clock edges after the capturing edge.
- R3: In unsigned mode (signed_i = 0), {hi_o, lo_o} equals the full 2N-bit unsigned product of mcand_i and mplier_i, including products that use the top bit of the result.
- R4: In signed mode (signed_i = 1), {hi_o, lo_o} equals the 2N-bit two's complement product, including operands of zero, minus one and the most negative value.
- R5: In signed mode, each step examines the current lowest product bit together with the bit shifted out just before it. The pair 1,0 subtracts the multiplicand, 0,1 adds it, and equal bits leave the sum unchanged. In unsigned mode no step ever subtracts. For N = 4, signed 2 × (−3) gives 8'b1111_1010 and signed 2 × 7 gives 8'b0000_1110.
- R6: start_i and new operand values presented while busy_o is high are ignored. The running result and the completion cycle are unaffected.
- R7: hi_o and lo_o change only on the edge that raises done_o. They keep their value while a later multiply is running and after it until that multiply completes.
- R8: done_o is a single-cycle pulse, and busy_o is low whenever done_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a multiply when idle |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| mcand_i | input | N | Multiplicand |
| mplier_i | input | N | Multiplier |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | N | Upper half of the product |
| lo_o | output | N | Lower half of the product |

## Verification
The hardest case to reach is a start pulse that arrives mid-operation carrying different operands. The block must ignore it completely, with no effect on the result or on the cycle in which done rises. The bench raises start with an inverted multiplicand one cycle into selected multiplies, and then checks both the product and the completion cycle. The sign-extension and carry corner cases are covered by an exhaustive sweep of every operand pair in both modes with N = 4. That sweep includes the most negative value and every add/subtract/hold sequence Booth recoding can form.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ADD  = 2'd1,
    STEP_SUB  = 2'd2
  } step_op_e;

endpackage

// File: rtl/booth_step_dec.sv
module booth_step_dec
  import booth_mul_pkg::*;
(
  input  logic     signed_mode_i,
  input  logic     cur_bit_i,
  input  logic     prev_bit_i,
  output step_op_e op_o
);

  always_comb begin
    if (signed_mode_i) begin
      case ({cur_bit_i, prev_bit_i})
        2'b10:   op_o = STEP_SUB;
        2'b01:   op_o = STEP_ADD;
        default: op_o = STEP_HOLD;
      endcase
    end else begin
      op_o = cur_bit_i ? STEP_ADD : STEP_HOLD;
    end
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_mul_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] acc_i,
  input  logic [N-1:0] mcand_i,
  input  logic         sext_i,
  input  step_op_e     op_i,
  output logic [N:0]   res_o
);

  logic [N:0] acc_ext;
  logic [N:0] mc_ext;

  always_comb begin
    acc_ext = {sext_i & acc_i[N-1], acc_i};
    mc_ext  = {sext_i & mcand_i[N-1], mcand_i};
    case (op_i)
      STEP_ADD: res_o = acc_ext + mc_ext;
      STEP_SUB: res_o = acc_ext - mc_ext;
      default:  res_o = acc_ext;
    endcase
  end

endmodule

// File: rtl/booth_iter_cnt.sv
module booth_iter_cnt #(
  parameter int N = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic step_i,
  output logic last_o
);

  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(N - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == LAST_VAL);

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && last_o && !load_i) |=> (cnt_q == '0));

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_mul_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] mplier_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] hi_o,
  output logic [N-1:0] lo_o
);

  logic [N-1:0] upper_q, lower_q, mcand_q, hi_q, lo_q;
  logic         xbit_q, sgn_q, busy_q, done_q;
  logic         accept, last;
  logic [N:0]   sum;
  logic [N-1:0] upper_nx, lower_nx;
  step_op_e     op;

  assign accept = start_i && !busy_q;

  booth_step_dec u_dec (
    .signed_mode_i (sgn_q),
    .cur_bit_i     (lower_q[0]),
    .prev_bit_i    (xbit_q),
    .op_o          (op)
  );

  booth_addsub #(.N(N)) u_alu (
    .acc_i   (upper_q),
    .mcand_i (mcand_q),
    .sext_i  (sgn_q),
    .op_i    (op),
    .res_o   (sum)
  );

  booth_iter_cnt #(.N(N)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .step_i (busy_q),
    .last_o (last)
  );

  // one-place right shift of {guard, upper, lower}
  assign upper_nx = sum[N:1];
  assign lower_nx = {sum[0], lower_q[N-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      lower_q <= '0;
      mcand_q <= '0;
      xbit_q  <= 1'b0;
      sgn_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        upper_q <= '0;
        lower_q <= mplier_i;
        mcand_q <= mcand_i;
        xbit_q  <= 1'b0;
        sgn_q   <= signed_i;
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        upper_q <= upper_nx;
        lower_q <= lower_nx;
        xbit_q  <= lower_q[0];
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          hi_q   <= upper_nx;
          lo_q   <= lower_nx;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;

  // R2
  load_state_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy_q && upper_q == '0 && lower_q == $past(mplier_i) && !xbit_q));

  // R5
  no_sub_unsigned_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !sgn_q) |-> (op != STEP_SUB));

  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last && start_i) |=> (busy_q && $stable(mcand_q) && $stable(sgn_q)));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(hi_o) && $stable(lo_o)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

endmodule

// File: tb/booth_seq_mul_tb.sv
`timescale 1ns/1ps
module booth_seq_mul_tb_top;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         signed_i = 1'b0;
  logic [N-1:0] mcand_i = '0;
  logic [N-1:0] mplier_i = '0;
  logic         busy_o, done_o;
  logic [N-1:0] hi_o, lo_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  booth_seq_mul #(.N(N)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .signed_i (signed_i),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .hi_o     (hi_o),
    .lo_o     (lo_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] ref_prod(input logic [N-1:0] a, input logic [N-1:0] b, input bit sgn);
    logic signed [2*N-1:0] sa, sb;
    logic [2*N-1:0] ua, ub;
    if (sgn) begin
      sa = {{N{a[N-1]}}, a};
      sb = {{N{b[N-1]}}, b};
      return sa * sb;
    end
    ua = {{N{1'b0}}, a};
    ub = {{N{1'b0}}, b};
    return ua * ub;
  endfunction

  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit sgn,
                        input bit interfere, output logic [2*N-1:0] got);
    logic [2*N-1:0] exp;
    logic [N-1:0] ph, pl;
    exp = ref_prod(a, b, sgn);
    @(negedge clk);
    start_i = 1'b1; mcand_i = a; mplier_i = b; signed_i = sgn;
    @(negedge clk);
    start_i = 1'b0; mcand_i = ~a; mplier_i = ~b; signed_i = ~sgn;
    check(busy_o === 1'b1, "R2 busy after start", 64'(busy_o), 64'd1);
    ph = hi_o; pl = lo_o;
    for (int j = 1; j <= N; j++) begin
      start_i = (interfere && j == 1);
      @(negedge clk);
      start_i = 1'b0;
      if (j < N) begin
        check(busy_o === 1'b1 && done_o === 1'b0, "R2 still busy", 64'({busy_o, done_o}), 64'b10);
        check(hi_o === ph && lo_o === pl, "R7 hold while busy", 64'({hi_o, lo_o}), 64'({ph, pl}));
      end else begin
        check(done_o === 1'b1 && busy_o === 1'b0,
              interfere ? "R6 done timing with ignored start" : "R8 done at step N",
              64'({busy_o, done_o}), 64'b01);
        got = {hi_o, lo_o};
        check(got === exp, sgn ? (interfere ? "R6 R4 signed product" : "R4 signed product")
                               : (interfere ? "R6 R3 unsigned product" : "R3 unsigned product"),
              64'(got), 64'(exp));
      end
    end
    @(negedge clk);
    check(done_o === 1'b0, "R8 done single pulse", 64'(done_o), 64'd0);
    check({hi_o, lo_o} === exp, "R7 hold after done", 64'({hi_o, lo_o}), 64'(exp));
  endtask

  initial begin
    logic [2*N-1:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0, "R1 reset flags", 64'({busy_o, done_o}), 64'd0);
    check(hi_o === '0 && lo_o === '0, "R1 reset result", 64'({hi_o, lo_o}), 64'd0);

    run_op(4'd2, 4'b1101, 1'b1, 1'b0, r);
    check(r === 8'b1111_1010, "R5 signed 2 x -3", 64'(r), 64'hFA);
    run_op(4'd2, 4'd7, 1'b1, 1'b0, r);
    check(r === 8'b0000_1110, "R5 signed 2 x 7", 64'(r), 64'h0E);
    run_op(4'b1000, 4'b1000, 1'b1, 1'b1, r);
    check(r === 8'h40, "R4 most negative squared", 64'(r), 64'h40);
    run_op(4'hF, 4'hF, 1'b0, 1'b1, r);
    check(r === 8'hE1, "R3 max unsigned squared", 64'(r), 64'hE1);

    for (int s = 0; s < 2; s++)
      for (int a = 0; a < (1 << N); a++)
        for (int b = 0; b < (1 << N); b++)
          run_op(N'(a), N'(b), s[0], ((a + b) % 5) == 0, r);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule